// File: doc/BRIEF.md
# Single-Line Interrupt Sense Controller

This block takes one asynchronous interrupt request wire and turns it into one interrupt output for a parent interrupt controller. The raw wire is synchronised first. The synchronised level then goes to a detector that works in one of four trigger modes: active-high level, active-low level, rising edge or falling edge. Each detected event sets a sticky pending flag. An enable bit gates that flag onto the output.

Software reaches the block through a simple register bus with a 32-bit word. There is one address, one write strobe and write data, and read data comes back combinationally. Three registers are mapped: trigger control, pending and output enable. A parameter picks one of two offset layouts, so one design fits either address map. The usual bring-up sequence is: disable the output, clear pending, set the trigger mode, then enable the output. After servicing an interrupt, the handler clears pending.

Top module: `irq_sense_ctrl`

## Requirements
- R1: The input wire passes through a two-stage synchroniser, and the detector also keeps the previous synchronised sample. In an enabled high-level mode, a rise on `lineIn` driven between edges shows on `irqOut` only after the third rising clock edge.
- R2: Control register bits [1:0] select the trigger mode. Code 2 is active-high level and code 0 is active-low level. Code 3 is a rising edge, seen when the previous sample was 0 and the current one is 1. Code 1 is a falling edge.
- R3: In the edge modes, one transition sets pending once. After a clear, pending stays 0 while the input holds steady.
- R4: In the level modes, pending sets again on the clock after a clear while the input is still active. Once the input goes inactive, a clear leaves pending at 0.
- R5: The pending flag sits at bit 0 of the pending register. Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R6: If a clear write and a detected event fall in the same cycle, the event wins and pending stays 1.
- R7: An event sets pending whatever the enable state. `irqOut` is high exactly when pending is 1 and enable bit 0 is 1.
- R8: With `LAYOUT_B`=0 the control, pending and enable registers sit at 0x00, 0x04 and 0x08. With `LAYOUT_B`=1 they sit at 0x0C, 0x10 and 0x40.
- R9: All registers reset to 0. Unused bits read 0 and ignore writes. A read at any unmapped offset returns 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWrite | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr`, combinational |
| lineIn | input | 1 | Raw asynchronous interrupt request |
| irqOut | output | 1 | Interrupt to the parent controller |

## Verification
The two functions that can coincide are the software clear of pending and a newly detected event. The bench times a rising transition on `lineIn` so that the detector fires in the very cycle that a write of 1 to the pending bit is presented. The bench then expects pending to read back as 1. Level modes provoke the same collision on every clear while the input stays active. A behavioural cycle model compares `irqOut` and the read data of both layouts on every clock, so any wrong priority between the two functions is caught in the cycle where it happens.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW_LEVEL  = 2'd0,
    TRIG_FALL_EDGE  = 2'd1,
    TRIG_HIGH_LEVEL = 2'd2,
    TRIG_RISE_EDGE  = 2'd3
  } trig_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_PEND = 2'd2,
    SEL_EN   = 2'd3
  } rdSel_t;

  typedef struct packed {
    logic   ctrlWr;
    logic   enWr;
    logic   pendClr;
    rdSel_t rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irq_sense_sync.sv
module irq_sense_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_sense_decode.sv
module irq_sense_decode
  import irq_sense_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter bit LAYOUT_B = 1'b0
) (
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] CTRL_OFF = LAYOUT_B ? ADDR_W'('h0C) : ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] PEND_OFF = LAYOUT_B ? ADDR_W'('h10) : ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] EN_OFF   = LAYOUT_B ? ADDR_W'('h40) : ADDR_W'('h08);

  logic hitCtrl, hitPend, hitEn;
  logic unusedWdata;

  assign hitCtrl = (busAddr == CTRL_OFF);
  assign hitPend = (busAddr == PEND_OFF);
  assign hitEn   = (busAddr == EN_OFF);
  assign unusedWdata = ^busWdata[DATA_W-1:1];

  always_comb begin
    strobe.ctrlWr  = busWrite && hitCtrl;
    strobe.enWr    = busWrite && hitEn;
    strobe.pendClr = busWrite && hitPend && busWdata[0];
    if (hitCtrl)      strobe.rdSel = SEL_CTRL;
    else if (hitPend) strobe.rdSel = SEL_PEND;
    else if (hitEn)   strobe.rdSel = SEL_EN;
    else              strobe.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/irq_sense_datapath.sv
module irq_sense_datapath
  import irq_sense_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  regStrobe_t        strobe,
  input  logic [1:0]        wrBits,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic [1:0]        trigQ,
  output logic              pendQ,
  output logic              enQ,
  output logic              syncQ,
  output logic              prevQ
);
  localparam int PAD_W = DATA_W - 2;

  trig_t trigReg;
  logic  eventHit;

  irq_sense_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (lineIn),
    .q   (syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ;
  end

  always_comb begin
    unique case (trigReg)
      TRIG_LOW_LEVEL:  eventHit = !syncQ;
      TRIG_FALL_EDGE:  eventHit = prevQ && !syncQ;
      TRIG_HIGH_LEVEL: eventHit = syncQ;
      TRIG_RISE_EDGE:  eventHit = !prevQ && syncQ;
      default:         eventHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigReg <= TRIG_LOW_LEVEL;
      enQ     <= 1'b0;
      pendQ   <= 1'b0;
    end else begin
      if (strobe.ctrlWr) trigReg <= trig_t'(wrBits);
      if (strobe.enWr)   enQ     <= wrBits[0];
      if (eventHit)            pendQ <= 1'b1;
      else if (strobe.pendClr) pendQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_CTRL: busRdata = {{PAD_W{1'b0}}, trigReg};
      SEL_PEND: busRdata = {{(DATA_W-1){1'b0}}, pendQ};
      SEL_EN:   busRdata = {{(DATA_W-1){1'b0}}, enQ};
      default:  busRdata = '0;
    endcase
  end

  assign trigQ  = trigReg;
  assign irqOut = pendQ && enQ;
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit LAYOUT_B    = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              lineIn,
  output logic              irqOut
);
  regStrobe_t strobe;
  logic [1:0] trigQ;
  logic       pendQ, enQ, syncQ, prevQ, pendClr;

  assign pendClr = strobe.pendClr;

  irq_sense_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LAYOUT_B(LAYOUT_B)
  ) u_dec (
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strobe  (strobe)
  );

  irq_sense_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (lineIn),
    .strobe  (strobe),
    .wrBits  (busWdata[1:0]),
    .busRdata(busRdata),
    .irqOut  (irqOut),
    .trigQ   (trigQ),
    .pendQ   (pendQ),
    .enQ     (enQ),
    .syncQ   (syncQ),
    .prevQ   (prevQ)
  );
endmodule

// File: rtl/irq_sense_checker.sv
module irq_sense_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              pendClr,
  input logic [1:0]        trigQ,
  input logic              pendQ,
  input logic              enQ,
  input logic              syncQ,
  input logic              prevQ
);
  // R1: the detector's previous sample trails the synchronised level by one clock
  a_r1_prev_tracks: assert property (@(posedge clk) disable iff (!rstN)
    prevQ == $past(syncQ));

  // R2: a rise of pending in rising-edge mode needs a 0-to-1 step in the samples
  a_r2_rise_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pendQ) && $past(trigQ) == 2'd3) |-> $past(syncQ && !prevQ));

  // R4: an active high level always leaves pending set on the next clock
  a_r4_level_resets: assert property (@(posedge clk) disable iff (!rstN)
    (trigQ == 2'd2 && syncQ) |=> pendQ);

  // R5: pending is sticky until a clear is presented
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !pendClr) |=> pendQ);

  // R6: a clear colliding with an active-level event does not drop pending
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr && trigQ == 2'd0 && !syncQ) |=> pendQ);

  // R7: the output stays low while the enable bit is clear
  a_r7_off_silent: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !irqOut);

  // R9: only the two low bits of read data can ever be non-zero
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:2] == '0);
endmodule

bind irq_sense_ctrl irq_sense_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .pendClr (pendClr),
  .trigQ   (trigQ),
  .pendQ   (pendQ),
  .enQ     (enQ),
  .syncQ   (syncQ),
  .prevQ   (prevQ)
);

// File: tb/sim_irq_sense_ctrl.sv
`timescale 1ns/1ps
module sim_irq_sense_ctrl;
  localparam int IDX_CTRL = 0, IDX_PEND = 1, IDX_EN = 2, IDX_NONE = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addrA = 8'h20, addrB = 8'h20;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdA, rdB;
  logic        lineIn = 1'b1;
  logic        irqA, irqB;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // behavioural reference state
  int  hist[$];
  int  mMode = 0;
  bit  mPend = 0;
  bit  mEn = 0;

  always #2.5 clk = ~clk;

  irq_sense_ctrl #(.LAYOUT_B(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(addrA), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(rdA), .lineIn(lineIn), .irqOut(irqA));

  irq_sense_ctrl #(.LAYOUT_B(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .busAddr(addrB), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(rdB), .lineIn(lineIn), .irqOut(irqB));

  function automatic logic [31:0] expRead(bit layB, logic [7:0] a);
    logic [7:0] oc, op, oe;
    oc = layB ? 8'h0C : 8'h00;
    op = layB ? 8'h10 : 8'h04;
    oe = layB ? 8'h40 : 8'h08;
    if (a == oc)      return 32'(mMode);
    else if (a == op) return {31'd0, mPend};
    else if (a == oe) return {31'd0, mEn};
    else              return 32'd0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: advances on every edge, then compares both layouts
  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{0, 0, 0};
      mMode = 0; mPend = 0; mEn = 0;
    end else begin
      bit cur, old, ev, clr;
      cur = hist[1] != 0;
      old = hist[2] != 0;
      case (mMode)
        0: ev = !cur;
        1: ev = old && !cur;
        2: ev = cur;
        default: ev = !old && cur;
      endcase
      clr = busWrite && addrA == 8'h04 && busWdata[0];
      if (ev) mPend = 1;
      else if (clr) mPend = 0;
      if (busWrite && addrA == 8'h00) mMode = int'(busWdata[1:0]);
      if (busWrite && addrA == 8'h08) mEn = busWdata[0];
      hist.push_front(int'(lineIn));
      void'(hist.pop_back());
      #1;
      check({31'd0, irqA}, {31'd0, mPend && mEn}, "R7 layoutA irq");
      check({31'd0, irqB}, {31'd0, mPend && mEn}, "R7 layoutB irq");
      check(rdA, expRead(1'b0, addrA), "R8 layoutA read");
      check(rdB, expRead(1'b1, addrB), "R8 layoutB read");
    end
  end

  function automatic logic [7:0] offA(int idx);
    case (idx) 0: return 8'h00; 1: return 8'h04; 2: return 8'h08; default: return 8'h20; endcase
  endfunction
  function automatic logic [7:0] offB(int idx);
    case (idx) 0: return 8'h0C; 1: return 8'h10; 2: return 8'h40; default: return 8'h20; endcase
  endfunction

  task automatic wrRaw(input logic [7:0] aA, input logic [7:0] aB, input logic [31:0] d);
    @(negedge clk);
    addrA = aA; addrB = aB; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wrRaw(offA(idx), offB(idx), d);
  endtask

  task automatic rdRaw(input logic [7:0] aA, input logic [7:0] aB,
                       input logic [31:0] expA, input logic [31:0] expB, input string tag);
    @(negedge clk);
    addrA = aA; addrB = aB;
    #1;
    check(rdA, expA, tag);
    check(rdB, expB, tag);
  endtask

  task automatic rdChk(input int idx, input logic [31:0] exp, input string tag);
    rdRaw(offA(idx), offB(idx), exp, exp, tag);
  endtask

  task automatic chkIrq(input bit exp, input string tag);
    check({31'd0, irqA}, {31'd0, exp}, tag);
    check({31'd0, irqB}, {31'd0, exp}, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R9: every register reads zero while reset is held
    rdChk(IDX_CTRL, 0, "R9 reset ctrl");
    rdChk(IDX_PEND, 0, "R9 reset pend");
    rdChk(IDX_EN, 0, "R9 reset en");
    @(negedge clk) rstN = 1'b1;
    idle(4);
    // R2: mode 0 is active-low level and the synchroniser starts at 0
    rdChk(IDX_PEND, 1, "R2 low level after reset");
    wr(IDX_EN, 0);
    wr(IDX_PEND, 1);
    idle(2);
    rdChk(IDX_PEND, 0, "R5 clear by writing 1");
    // R9: upper control bits ignore writes
    wr(IDX_CTRL, 32'hFFFF_FFFE);
    rdChk(IDX_CTRL, 2, "R9 ctrl unused bits");
    rdChk(IDX_PEND, 1, "R2 high level sets pending");
    wr(IDX_EN, 32'hFFFF_FFFF);
    rdChk(IDX_EN, 1, "R9 enable unused bits");
    @(negedge clk) #1 chkIrq(1, "R7 output follows pend and enable");
    wr(IDX_PEND, 1);
    rdChk(IDX_PEND, 1, "R4 level re-sets after clear");
    // R1: latency through the synchroniser and detector
    @(negedge clk) lineIn = 1'b0;
    idle(4);
    wr(IDX_PEND, 1);
    idle(1);
    rdChk(IDX_PEND, 0, "R1 pending clear before rise");
    @(negedge clk) lineIn = 1'b1;
    @(negedge clk) #1 chkIrq(0, "R1 after first edge");
    @(negedge clk) #1 chkIrq(0, "R1 after second edge");
    @(negedge clk) #1 chkIrq(1, "R1 after third edge");
    // R7: pending sets with the output disabled
    wr(IDX_CTRL, 3);
    wr(IDX_EN, 0);
    @(negedge clk) lineIn = 1'b0;
    idle(4);
    wr(IDX_PEND, 1);
    idle(2);
    rdChk(IDX_PEND, 0, "R3 steady low no rise");
    @(negedge clk) lineIn = 1'b1;
    idle(4);
    rdChk(IDX_PEND, 1, "R7 pending while disabled");
    chkIrq(0, "R7 gated by enable");
    wr(IDX_EN, 1);
    @(negedge clk) #1 chkIrq(1, "R7 released by enable");
    wr(IDX_PEND, 0);
    rdChk(IDX_PEND, 1, "R5 write 0 no effect");
    wr(IDX_PEND, 1);
    idle(3);
    rdChk(IDX_PEND, 0, "R3 rising edge sets once");
    // falling edge
    wr(IDX_CTRL, 1);
    @(negedge clk) lineIn = 1'b0;
    idle(4);
    rdChk(IDX_PEND, 1, "R2 falling edge");
    wr(IDX_PEND, 1);
    idle(3);
    rdChk(IDX_PEND, 0, "R3 falling edge sets once");
    // R6: clear presented in the cycle the rising edge is detected
    wr(IDX_CTRL, 3);
    @(negedge clk) lineIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addrA = offA(IDX_PEND); addrB = offB(IDX_PEND); busWdata = 32'd1; busWrite = 1'b1;
    @(negedge clk) busWrite = 1'b0;
    rdChk(IDX_PEND, 1, "R6 event beats clear");
    // low level
    wr(IDX_CTRL, 0);
    @(negedge clk) lineIn = 1'b0;
    wr(IDX_PEND, 1);
    idle(3);
    rdChk(IDX_PEND, 1, "R2 low level");
    @(negedge clk) lineIn = 1'b1;
    idle(4);
    wr(IDX_PEND, 1);
    idle(2);
    rdChk(IDX_PEND, 0, "R4 inactive level stays clear");
    // R8: layouts
    wr(IDX_CTRL, 3);
    rdRaw(8'h00, 8'h0C, 3, 3, "R8 control offsets");
    rdRaw(8'h0C, 8'h00, 0, 0, "R8 swapped offsets unmapped");
    rdRaw(8'h04, 8'h10, 0, 0, "R8 pending offsets");
    rdRaw(8'h08, 8'h40, 1, 1, "R8 enable offsets");
    wrRaw(8'h20, 8'h20, 32'hFFFF_FFFF);
    rdRaw(8'h20, 8'h20, 0, 0, "R9 unmapped read");
    rdChk(IDX_CTRL, 3, "R9 unmapped write ignored");
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule